// File: doc/BRIEF.md
# USB Endpoint Packet FIFO Port

This block is the processor-facing data port of a USB device controller's endpoint packet buffers. A simple register bus gives each of sixteen endpoints one data address. A write to that address appends bytes to the endpoint's transmit packet. A read from the same address removes bytes from the endpoint's oldest received packet. Each access moves one, two or four bytes. The bytes sit on the low lanes of the 32-bit data bus in little-endian order, so a packet can be built or consumed with a run of equal-width accesses and end with a shorter one.

Software finishes each transmit packet with a commit strobe. The USB side then drains committed packets one byte at a time, oldest first. On the receive side, the USB side pushes bytes and marks the last byte, which hands the packet to software. A configuration bit per endpoint selects one or two packet slots. With two slots, one packet can be drained while the next is being filled. Flush inputs for stall and transmit strike-out events empty both directions of endpoints 1 to 15. Endpoint 0 ignores them.

Top module: `usb_ep_fifo_port`

## Requirements
- R1: An access with `cpu_sel` high at an address in 20h..5Fh selects endpoint (addr-20h)/4, and the two low address bits are ignored. An access outside that range has no effect and reads return 0.
- R2: `cpu_size` 00 moves one byte on lanes [7:0], 01 moves two bytes on [15:0], and 10 moves four bytes on [31:0]. Lane 0 comes first in the packet. An access with size 11 has no effect.
- R3: After `cpu_commit` for endpoint n, `usb_tx_avail[n]` is high and the packet is held unchanged until it is drained. Each `usb_tx_rd` pop shows the next byte in write order on `usb_tx_byte`. `usb_tx_cnt` gives the bytes still to be drained.
- R4: A read asking for more bytes than remain in the packet returns the remaining bytes on the low lanes with zeros above, and it ends the packet.
- R5: In single-slot mode, a write after commit and before the drain is dropped and sets the sticky `cpu_tx_ovr[n]`. The sticky flags clear only at reset.
- R6: In double-slot mode, two packets can be committed. They drain in commit order, and a write while both are pending is dropped and sets `cpu_tx_ovr[n]`.
- R7: A `usb_rx_wr` byte with `usb_rx_end` commits a receive packet. For the addressed endpoint, `cpu_rx_cnt` shows the unread bytes and `cpu_rx_empty` is low. `usb_rx_space[n]` falls when no free receive slot is left.
- R8: A read from an endpoint with no received packet returns 0 and sets the sticky `cpu_rx_udr[n]`.
- R9: A `flush_stall[n]` or `flush_strike[n]` pulse on endpoint 1..15 discards every transmit and receive packet of that endpoint by the next cycle.
- R10: Endpoint 0 ignores both flush inputs.
- R11: A packet slot holds at most SLOT_BYTES (default 16). Bytes beyond that are dropped and set `cpu_tx_ovr[n]`.
- R12: After reset, no transmit packet is available, every receive slot is free, every receive FIFO reads empty, and the sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ep_dbl | input | 16 | Per-endpoint double-slot select |
| cpu_sel | input | 1 | Bus access strobe |
| cpu_wr | input | 1 | 1 = write to transmit, 0 = read from receive |
| cpu_addr | input | 8 | Byte address |
| cpu_size | input | 2 | Access width: 00 byte, 01 halfword, 10 word |
| cpu_wdata | input | 32 | Write data, little-endian lanes |
| cpu_rdata | output | 32 | Read data for the current access |
| cpu_commit | input | 1 | Commit the transmit packet being filled |
| cpu_commit_ep | input | 4 | Endpoint for the commit |
| cpu_rx_cnt | output | 5 | Unread bytes of the addressed endpoint's oldest receive packet |
| cpu_rx_empty | output | 1 | Addressed endpoint has no receive packet |
| cpu_tx_ovr | output | 16 | Sticky dropped-write flags |
| cpu_rx_udr | output | 16 | Sticky empty-read flags |
| usb_tx_ep | input | 4 | Endpoint to drain |
| usb_tx_rd | input | 1 | Pop one transmit byte |
| usb_tx_byte | output | 8 | Current transmit byte |
| usb_tx_cnt | output | 5 | Bytes left in the oldest committed transmit packet |
| usb_tx_avail | output | 16 | Committed transmit packet present, per endpoint |
| usb_rx_ep | input | 4 | Endpoint to fill |
| usb_rx_wr | input | 1 | Push one receive byte |
| usb_rx_byte | input | 8 | Receive byte |
| usb_rx_end | input | 1 | Pushed byte ends the packet |
| usb_rx_space | output | 16 | Free receive slot present, per endpoint |
| flush_stall | input | 16 | Stall flush per endpoint |
| flush_strike | input | 16 | Strike-out flush per endpoint |

## Verification
The assertions rely on `ep_dbl` staying constant while packets are held. They also rely on a commit never being issued for a slot that is already pending, apart from the dropped case. The bench sets the slot mode once after reset, and it pushes receive bytes only while `usb_rx_space` shows a free slot. It drains only endpoints whose `usb_tx_avail` bit is set. Each scenario leaves its endpoints empty before the next one starts, so the availability vectors can be compared whole.

// File: rtl/usb_fifo_pkg.sv
package usb_fifo_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // number of bytes an access carries; zero marks a reserved size
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      SZ_WORD: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ep_addr_decode.sv
module ep_addr_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned BASE   = 32,
  parameter int unsigned EP_W   = $clog2(NUM_EP)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic [EP_W-1:0]   ep
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] NEP_V  = ADDR_W'(NUM_EP);

  logic [ADDR_W-1:0] off;
  logic [1:0]        lane_unused;

  always_comb begin
    off         = addr - BASE_V;
    in_range    = (addr >= BASE_V) && ({2'b00, off[ADDR_W-1:2]} < NEP_V);
    ep          = off[EP_W+1:2];
    lane_unused = off[1:0];
  end

endmodule

// File: rtl/pkt_slot_buf.sv
module pkt_slot_buf #(
  parameter int unsigned SLOT_BYTES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              dbl,
  input  logic                              flush,
  input  logic                              wr_en,
  input  logic [2:0]                        wr_nb,
  input  logic [31:0]                       wr_data,
  input  logic                              commit,
  input  logic                              rd_en,
  input  logic [2:0]                        rd_nb,
  output logic [31:0]                       rd_data,
  output logic                              rd_avail,
  output logic [$clog2(SLOT_BYTES+1)-1:0]   rd_rem,
  output logic                              wr_full,
  output logic                              wr_drop,
  output logic                              rd_under
);

  localparam int unsigned CNT_W = $clog2(SLOT_BYTES+1);
  localparam int unsigned POS_W = $clog2(SLOT_BYTES);
  localparam int unsigned LANES = 4;
  localparam logic [CNT_W:0] CAP = (CNT_W+1)'(SLOT_BYTES);

  // state
  logic [1:0]       vld_q, vld_n;
  logic [CNT_W-1:0] cnt_q [2];
  logic [CNT_W-1:0] cnt_n [2];
  logic [CNT_W-1:0] pos_q, pos_n;
  logic             wsel_q, wsel_n;
  logic             rsel_q, rsel_n;
  logic [7:0]       mem [2][SLOT_BYTES];

  // write side
  logic             wfree;
  logic [CNT_W-1:0] wbase;
  logic [CNT_W:0]   widx [LANES];
  logic [LANES-1:0] lane_we;
  logic [CNT_W-1:0] wr_acc;
  logic             over;
  logic             wr_take;

  // read side
  logic [CNT_W-1:0] head_cnt;
  logic [2:0]       take;
  logic [POS_W-1:0] ridx [LANES];
  logic             rd_fire;
  logic             pkt_done;

  always_comb begin
    wfree  = ~vld_q[wsel_q];
    wbase  = cnt_q[wsel_q];
    wr_acc = '0;
    for (int i = 0; i < LANES; i++) begin
      widx[i]    = {1'b0, wbase} + (CNT_W+1)'(i);
      lane_we[i] = wr_en && wfree && !flush && (3'(i) < wr_nb) && (widx[i] < CAP);
      wr_acc     = wr_acc + CNT_W'(lane_we[i]);
    end
    over     = wr_en && wfree && (({1'b0, wbase} + (CNT_W+1)'(wr_nb)) > CAP);
    wr_drop  = wr_en && !flush && (!wfree || over);
    wr_take  = wr_en && wfree && !flush;
    wr_full  = ~wfree;
  end

  always_comb begin
    head_cnt = cnt_q[rsel_q];
    rd_avail = vld_q[rsel_q];
    rd_rem   = rd_avail ? (head_cnt - pos_q) : '0;
    take     = (rd_rem < CNT_W'(rd_nb)) ? rd_rem[2:0] : rd_nb;
    for (int i = 0; i < LANES; i++) begin
      ridx[i]          = pos_q[POS_W-1:0] + POS_W'(i);
      rd_data[8*i +: 8] = (3'(i) < take) ? mem[rsel_q][ridx[i]] : 8'h00;
    end
    rd_fire  = rd_en && rd_avail && !flush;
    rd_under = rd_en && !rd_avail && !flush;
    pkt_done = ({1'b0, pos_q} + (CNT_W+1)'(take)) >= {1'b0, head_cnt};
  end

  // next state
  always_comb begin
    vld_n  = vld_q;
    cnt_n  = cnt_q;
    pos_n  = pos_q;
    wsel_n = wsel_q;
    rsel_n = rsel_q;
    if (flush) begin
      vld_n  = '0;
      cnt_n  = '{default: '0};
      pos_n  = '0;
      wsel_n = 1'b0;
      rsel_n = 1'b0;
    end else begin
      if (wr_take) begin
        cnt_n[wsel_q] = wbase + wr_acc;
      end
      if (commit && wfree) begin
        vld_n[wsel_q] = 1'b1;
        if (dbl) begin
          wsel_n = ~wsel_q;
        end
      end
      if (rd_fire) begin
        if (pkt_done) begin
          vld_n[rsel_q] = 1'b0;
          cnt_n[rsel_q] = '0;
          pos_n         = '0;
          if (dbl) begin
            rsel_n = ~rsel_q;
          end
        end else begin
          pos_n = pos_q + CNT_W'(take);
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      cnt_q  <= '{default: '0};
      pos_q  <= '0;
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      cnt_q  <= cnt_n;
      pos_q  <= pos_n;
      wsel_q <= wsel_n;
      rsel_q <= rsel_n;
    end
  end

  // byte storage, write-enabled per lane
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) begin
        mem[wsel_q][widx[i][POS_W-1:0]] <= wr_data[8*i +: 8];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[0] <= CNT_W'(SLOT_BYTES)) && (cnt_q[1] <= CNT_W'(SLOT_BYTES))); // R11

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rd_avail && !wr_full)); // R9

  AST_HOLD_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_avail && !rd_en && !flush) |=> (rd_avail && $stable(rd_rem))); // R3

  AST_ONE_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |-> !(vld_q[0] && vld_q[1])); // R5

endmodule

// File: rtl/usb_ep_fifo_port.sv
module usb_ep_fifo_port #(
  parameter int unsigned NUM_EP     = 16,
  parameter int unsigned SLOT_BYTES = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BASE       = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_EP-1:0]                   ep_dbl,
  input  logic                                cpu_sel,
  input  logic                                cpu_wr,
  input  logic [ADDR_W-1:0]                   cpu_addr,
  input  logic [1:0]                          cpu_size,
  input  logic [31:0]                         cpu_wdata,
  output logic [31:0]                         cpu_rdata,
  input  logic                                cpu_commit,
  input  logic [$clog2(NUM_EP)-1:0]           cpu_commit_ep,
  output logic [$clog2(SLOT_BYTES+1)-1:0]     cpu_rx_cnt,
  output logic                                cpu_rx_empty,
  output logic [NUM_EP-1:0]                   cpu_tx_ovr,
  output logic [NUM_EP-1:0]                   cpu_rx_udr,
  input  logic [$clog2(NUM_EP)-1:0]           usb_tx_ep,
  input  logic                                usb_tx_rd,
  output logic [7:0]                          usb_tx_byte,
  output logic [$clog2(SLOT_BYTES+1)-1:0]     usb_tx_cnt,
  output logic [NUM_EP-1:0]                   usb_tx_avail,
  input  logic [$clog2(NUM_EP)-1:0]           usb_rx_ep,
  input  logic                                usb_rx_wr,
  input  logic [7:0]                          usb_rx_byte,
  input  logic                                usb_rx_end,
  output logic [NUM_EP-1:0]                   usb_rx_space,
  input  logic [NUM_EP-1:0]                   flush_stall,
  input  logic [NUM_EP-1:0]                   flush_strike
);

  import usb_fifo_pkg::*;

  localparam int unsigned EP_W  = $clog2(NUM_EP);
  localparam int unsigned CNT_W = $clog2(SLOT_BYTES+1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s = rst_sync_q[1];

  // bus decode
  logic            in_range;
  logic [EP_W-1:0] cpu_ep;
  logic [2:0]      acc_nb;
  logic            cpu_wr_hit;
  logic            cpu_rd_hit;

  ep_addr_decode #(
    .ADDR_W (ADDR_W),
    .NUM_EP (NUM_EP),
    .BASE   (BASE),
    .EP_W   (EP_W)
  ) u_dec (
    .addr     (cpu_addr),
    .in_range (in_range),
    .ep       (cpu_ep)
  );

  always_comb begin
    acc_nb     = size_bytes(cpu_size);
    cpu_wr_hit = cpu_sel && cpu_wr  && in_range && (acc_nb != 3'd0);
    cpu_rd_hit = cpu_sel && !cpu_wr && in_range && (acc_nb != 3'd0);
  end

  // per-endpoint buffers
  logic [NUM_EP-1:0][7:0]  tx_byte;
  logic [NUM_EP-1:0][23:0] tx_hi_unused;
  logic [CNT_W-1:0]        tx_rem [NUM_EP];
  logic [NUM_EP-1:0]       tx_full_unused;
  logic [NUM_EP-1:0]       tx_drop;
  logic [NUM_EP-1:0]       tx_under_unused;
  logic [31:0]             rx_rdata [NUM_EP];
  logic [NUM_EP-1:0]       rx_avail;
  logic [CNT_W-1:0]        rx_rem [NUM_EP];
  logic [NUM_EP-1:0]       rx_full;
  logic [NUM_EP-1:0]       rx_drop_unused;
  logic [NUM_EP-1:0]       rx_under;
  logic                    ep0_flush_unused;

  assign ep0_flush_unused = flush_stall[0] | flush_strike[0];

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    logic ep_flush;
    if (n == 0) begin : g_ctl
      assign ep_flush = 1'b0;
    end else begin : g_fl
      assign ep_flush = flush_stall[n] | flush_strike[n];
    end

    pkt_slot_buf #(.SLOT_BYTES(SLOT_BYTES)) u_tx (
      .clk      (clk),
      .rst_n    (rst_s),
      .dbl      (ep_dbl[n]),
      .flush    (ep_flush),
      .wr_en    (cpu_wr_hit && (cpu_ep == EP_W'(n))),
      .wr_nb    (acc_nb),
      .wr_data  (cpu_wdata),
      .commit   (cpu_commit && (cpu_commit_ep == EP_W'(n))),
      .rd_en    (usb_tx_rd && (usb_tx_ep == EP_W'(n))),
      .rd_nb    (3'd1),
      .rd_data  ({tx_hi_unused[n], tx_byte[n]}),
      .rd_avail (usb_tx_avail[n]),
      .rd_rem   (tx_rem[n]),
      .wr_full  (tx_full_unused[n]),
      .wr_drop  (tx_drop[n]),
      .rd_under (tx_under_unused[n])
    );

    pkt_slot_buf #(.SLOT_BYTES(SLOT_BYTES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_s),
      .dbl      (ep_dbl[n]),
      .flush    (ep_flush),
      .wr_en    (usb_rx_wr && (usb_rx_ep == EP_W'(n))),
      .wr_nb    (3'd1),
      .wr_data  ({24'h000000, usb_rx_byte}),
      .commit   (usb_rx_wr && usb_rx_end && (usb_rx_ep == EP_W'(n))),
      .rd_en    (cpu_rd_hit && (cpu_ep == EP_W'(n))),
      .rd_nb    (acc_nb),
      .rd_data  (rx_rdata[n]),
      .rd_avail (rx_avail[n]),
      .rd_rem   (rx_rem[n]),
      .wr_full  (rx_full[n]),
      .wr_drop  (rx_drop_unused[n]),
      .rd_under (rx_under[n])
    );
  end

  // output muxing
  always_comb begin
    cpu_rdata    = cpu_rd_hit ? rx_rdata[cpu_ep] : 32'h0;
    cpu_rx_cnt   = in_range ? rx_rem[cpu_ep] : '0;
    cpu_rx_empty = in_range ? ~rx_avail[cpu_ep] : 1'b1;
    usb_tx_byte  = tx_byte[usb_tx_ep];
    usb_tx_cnt   = tx_rem[usb_tx_ep];
    usb_rx_space = ~rx_full;
  end

  // sticky error flags
  logic [NUM_EP-1:0] ovr_q, ovr_n;
  logic [NUM_EP-1:0] udr_q, udr_n;

  always_comb begin
    ovr_n = ovr_q | tx_drop;
    udr_n = udr_q | rx_under;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ovr_q <= '0;
      udr_q <= '0;
    end else begin
      ovr_q <= ovr_n;
      udr_q <= udr_n;
    end
  end

  assign cpu_tx_ovr = ovr_q;
  assign cpu_rx_udr = udr_q;

  AST_EP0_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_s)
    (usb_tx_avail[0] && !(usb_tx_rd && (usb_tx_ep == '0))) |=> usb_tx_avail[0]); // R10

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_rd_hit && cpu_rx_empty) |-> (cpu_rdata == 32'h0)); // R8

  AST_STICKY_OVR: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_tx_ovr != '0) |=> ((cpu_tx_ovr & $past(cpu_tx_ovr)) == $past(cpu_tx_ovr))); // R5

  AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_sel && !cpu_wr && !in_range) |-> (cpu_rdata == 32'h0)); // R1

endmodule

// File: tb/usb_ep_fifo_port_test.sv
module usb_ep_fifo_port_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] ep_dbl;
  logic        cpu_sel, cpu_wr;
  logic [7:0]  cpu_addr;
  logic [1:0]  cpu_size;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_commit;
  logic [3:0]  cpu_commit_ep;
  logic [4:0]  cpu_rx_cnt;
  logic        cpu_rx_empty;
  logic [15:0] cpu_tx_ovr, cpu_rx_udr;
  logic [3:0]  usb_tx_ep;
  logic        usb_tx_rd;
  logic [7:0]  usb_tx_byte;
  logic [4:0]  usb_tx_cnt;
  logic [15:0] usb_tx_avail;
  logic [3:0]  usb_rx_ep;
  logic        usb_rx_wr;
  logic [7:0]  usb_rx_byte;
  logic        usb_rx_end;
  logic [15:0] usb_rx_space;
  logic [15:0] flush_stall, flush_strike;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  usb_ep_fifo_port uut (
    .clk, .rst_n, .ep_dbl, .cpu_sel, .cpu_wr, .cpu_addr, .cpu_size,
    .cpu_wdata, .cpu_rdata, .cpu_commit, .cpu_commit_ep, .cpu_rx_cnt,
    .cpu_rx_empty, .cpu_tx_ovr, .cpu_rx_udr, .usb_tx_ep, .usb_tx_rd,
    .usb_tx_byte, .usb_tx_cnt, .usb_tx_avail, .usb_rx_ep, .usb_rx_wr,
    .usb_rx_byte, .usb_rx_end, .usb_rx_space, .flush_stall, .flush_strike
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ep_addr(input int ep);
    return 8'(32 + 4 * ep);
  endfunction

  task automatic cpu_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_size = sz; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a; cpu_size = sz;
    #1 d = cpu_rdata;
    @(posedge clk); #1;
    cpu_sel = 1'b0;
  endtask

  task automatic commit(input int ep);
    @(negedge clk);
    cpu_commit = 1'b1; cpu_commit_ep = 4'(ep);
    @(posedge clk); #1;
    cpu_commit = 1'b0;
  endtask

  task automatic usb_push(input int ep, input logic [7:0] b, input logic last);
    @(negedge clk);
    usb_rx_wr = 1'b1; usb_rx_ep = 4'(ep); usb_rx_byte = b; usb_rx_end = last;
    @(posedge clk); #1;
    usb_rx_wr = 1'b0; usb_rx_end = 1'b0;
  endtask

  task automatic pop_byte(input int ep, input logic [7:0] exp, input string req);
    @(negedge clk);
    usb_tx_ep = 4'(ep); usb_tx_rd = 1'b1;
    #1 chk(req, {24'h0, usb_tx_byte}, {24'h0, exp});
    @(posedge clk); #1;
    usb_tx_rd = 1'b0;
  endtask

  task automatic tx_cnt_is(input int ep, input int exp, input string req);
    @(negedge clk);
    usb_tx_ep = 4'(ep);
    #1 chk(req, {27'h0, usb_tx_cnt}, 32'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R12 tx avail", {16'h0, usb_tx_avail}, 32'h0);
    chk("R12 rx space", {16'h0, usb_rx_space}, 32'h0000_FFFF);
    chk("R12 ovr", {16'h0, cpu_tx_ovr}, 32'h0);
    chk("R12 udr", {16'h0, cpu_rx_udr}, 32'h0);
    cpu_addr = ep_addr(6);
    #1 chk("R12 rx empty", {31'h0, cpu_rx_empty}, 32'h1);
  endtask

  task automatic t_mixed_tx;
    cpu_write(ep_addr(3), 2'b01, 32'hFFFF_2211);
    cpu_write(ep_addr(3), 2'b11, 32'hDEAD_BEEF);   // reserved size, R2
    cpu_write(ep_addr(3), 2'b01, 32'hFFFF_4433);
    cpu_write(ep_addr(3), 2'b00, 32'hFFFF_FF55);
    commit(3);
    #1 chk("R3 avail ep3", {16'h0, usb_tx_avail}, 32'h0000_0008);
    tx_cnt_is(3, 5, "R3 count ep3");
    pop_byte(3, 8'h11, "R2 half lane0");
    pop_byte(3, 8'h22, "R2 half lane1");
    pop_byte(3, 8'h33, "R2 half2 lane0");
    pop_byte(3, 8'h44, "R2 half2 lane1");
    pop_byte(3, 8'h55, "R3 short last byte");
    chk("R3 drained ep3", {16'h0, usb_tx_avail}, 32'h0);
    cpu_write(ep_addr(5), 2'b10, 32'hDDCC_BBAA);
    cpu_write(ep_addr(5), 2'b00, 32'h0000_00EE);
    commit(5);
    tx_cnt_is(5, 5, "R2 word count");
    pop_byte(5, 8'hAA, "R2 word lane0");
    pop_byte(5, 8'hBB, "R2 word lane1");
    pop_byte(5, 8'hCC, "R2 word lane2");
    pop_byte(5, 8'hDD, "R2 word lane3");
    pop_byte(5, 8'hEE, "R2 word tail");
  endtask

  task automatic t_decode;
    logic [31:0] d;
    cpu_write(8'h5F, 2'b00, 32'h0000_0077);   // endpoint 15, low bits ignored
    cpu_write(8'h60, 2'b10, 32'h1234_5678);   // outside
    cpu_write(8'h1F, 2'b00, 32'h0000_0099);   // outside
    commit(15);
    #1 chk("R1 only ep15", {16'h0, usb_tx_avail}, 32'h0000_8000);
    tx_cnt_is(15, 1, "R1 ep15 count");
    pop_byte(15, 8'h77, "R1 ep15 byte");
    chk("R1 ovr clean", {16'h0, cpu_tx_ovr}, 32'h0);
    usb_push(1, 8'h5A, 1'b1);
    cpu_read(8'h60, 2'b10, d);
    chk("R1 outside read", d, 32'h0);
    cpu_addr = ep_addr(1);
    #1 chk("R1 outside read kept packet", {27'h0, cpu_rx_cnt}, 32'd1);
    cpu_read(8'h26, 2'b00, d);
    chk("R1 ep1 read", d, 32'h0000_005A);
    chk("R1 udr clean", {16'h0, cpu_rx_udr}, 32'h0);
  endtask

  task automatic t_single_ovr;
    cpu_write(ep_addr(2), 2'b00, 32'h0000_0031);
    commit(2);
    cpu_write(ep_addr(2), 2'b00, 32'h0000_0032);
    chk("R5 ovr set", {16'h0, cpu_tx_ovr}, 32'h0000_0004);
    tx_cnt_is(2, 1, "R5 packet intact");
    pop_byte(2, 8'h31, "R5 byte");
    chk("R5 drained", {31'h0, usb_tx_avail[2]}, 32'h0);
    chk("R5 ovr sticky", {16'h0, cpu_tx_ovr}, 32'h0000_0004);
  endtask

  task automatic t_double;
    cpu_write(ep_addr(4), 2'b00, 32'h0000_00A1);
    commit(4);
    cpu_write(ep_addr(4), 2'b01, 32'h0000_B2B1);
    commit(4);
    cpu_write(ep_addr(4), 2'b00, 32'h0000_00C1);
    chk("R6 third dropped", {31'h0, cpu_tx_ovr[4]}, 32'h1);
    tx_cnt_is(4, 1, "R6 oldest first count");
    pop_byte(4, 8'hA1, "R6 first packet");
    tx_cnt_is(4, 2, "R6 second count");
    pop_byte(4, 8'hB1, "R6 second b0");
    pop_byte(4, 8'hB2, "R6 second b1");
    chk("R6 both drained", {31'h0, usb_tx_avail[4]}, 32'h0);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    usb_push(6, 8'h10, 1'b0);
    usb_push(6, 8'h20, 1'b0);
    usb_push(6, 8'h30, 1'b1);
    cpu_addr = ep_addr(6);
    #1 chk("R7 rx count", {27'h0, cpu_rx_cnt}, 32'd3);
    chk("R7 rx not empty", {31'h0, cpu_rx_empty}, 32'h0);
    chk("R7 no space single", {31'h0, usb_rx_space[6]}, 32'h0);
    cpu_read(ep_addr(6), 2'b01, d);
    chk("R7 half read", d, 32'h0000_2010);
    cpu_read(ep_addr(6), 2'b01, d);
    chk("R4 short read", d, 32'h0000_0030);
    cpu_addr = ep_addr(6);
    #1 chk("R4 packet ended", {31'h0, cpu_rx_empty}, 32'h1);
    chk("R7 space back", {31'h0, usb_rx_space[6]}, 32'h1);
    cpu_read(ep_addr(6), 2'b10, d);
    chk("R8 empty read zero", d, 32'h0);
    chk("R8 udr set", {16'h0, cpu_rx_udr}, 32'h0000_0040);
  endtask

  task automatic t_flush;
    cpu_write(ep_addr(7), 2'b10, 32'h0403_0201);
    commit(7);
    usb_push(7, 8'h61, 1'b1);
    cpu_write(ep_addr(8), 2'b00, 32'h0000_0081);
    commit(8);
    chk("R9 pre avail", {16'h0, usb_tx_avail}, 32'h0000_0180);
    @(negedge clk);
    flush_stall[7] = 1'b1; flush_strike[8] = 1'b1;
    @(posedge clk); #1;
    flush_stall = '0; flush_strike = '0;
    chk("R9 tx flushed", {16'h0, usb_tx_avail}, 32'h0);
    chk("R9 rx space", {31'h0, usb_rx_space[7]}, 32'h1);
    cpu_addr = ep_addr(7);
    #1 chk("R9 rx empty", {31'h0, cpu_rx_empty}, 32'h1);
  endtask

  task automatic t_ep0;
    logic [31:0] d;
    cpu_write(ep_addr(0), 2'b01, 32'h0000_0B0A);
    commit(0);
    usb_push(0, 8'h0C, 1'b1);
    @(negedge clk);
    flush_stall[0] = 1'b1; flush_strike[0] = 1'b1;
    @(posedge clk); #1;
    flush_stall = '0; flush_strike = '0;
    chk("R10 ep0 tx kept", {31'h0, usb_tx_avail[0]}, 32'h1);
    tx_cnt_is(0, 2, "R10 ep0 count kept");
    pop_byte(0, 8'h0A, "R10 ep0 b0");
    pop_byte(0, 8'h0B, "R10 ep0 b1");
    cpu_read(ep_addr(0), 2'b00, d);
    chk("R10 ep0 rx kept", d, 32'h0000_000C);
  endtask

  task automatic t_slot_overflow;
    for (int k = 0; k < 5; k++) begin
      cpu_write(ep_addr(9), 2'b10,
                {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    end
    commit(9);
    chk("R11 ovr set", {31'h0, cpu_tx_ovr[9]}, 32'h1);
    tx_cnt_is(9, 16, "R11 capped count");
    for (int k = 0; k < 16; k++) begin
      pop_byte(9, 8'(k), "R11 kept byte");
    end
    chk("R11 drained", {31'h0, usb_tx_avail[9]}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; ep_dbl = 16'h0010;
    cpu_sel = 0; cpu_wr = 0; cpu_addr = 0; cpu_size = 0; cpu_wdata = 0;
    cpu_commit = 0; cpu_commit_ep = 0;
    usb_tx_ep = 0; usb_tx_rd = 0; usb_rx_ep = 0; usb_rx_wr = 0;
    usb_rx_byte = 0; usb_rx_end = 0; flush_stall = 0; flush_strike = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_mixed_tx();
    t_decode();
    t_single_ovr();
    t_double();
    t_rx();
    t_flush();
    t_ep0();
    t_slot_overflow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule